// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host reach an external asynchronous static RAM of 128K words by 8 bits. The host raises a request for one cycle, with a write flag, a 17-bit word address and a write byte. The sequencer captures these values, selects the memory and steps through a fixed series of phases. It then pulses done for one cycle. For a read, the byte taken from the memory is presented together with that pulse. Each phase length is a clock-cycle count set by a parameter. A slower or faster memory grade, or a different clock rate, is handled by changing these counts.

The memory side drives an address bus and two chip selects of opposite polarity: an active-low select and an active-high select. These are always both active or both inactive. It also drives an active-low write strobe and an active-low output-enable strobe. The bidirectional data bus is split into an outgoing byte, an incoming byte and a drive enable for the pad.

States are named as follows. ST_IDLE deselects the memory. ST_WSET sets up address and data. ST_WPUL holds the write strobe. ST_WREC releases the strobe while still driving data. ST_RTRN is the bus turnaround. ST_RACC holds the output enable. ST_RFIN ends the read.

Transitions are named as follows. ST_IDLE goes on a request to ST_WSET for a write or to ST_RTRN for a read. ST_WSET goes to ST_WPUL, and ST_WPUL to ST_WREC, each when its count expires. ST_WREC returns to ST_IDLE. ST_RTRN goes to ST_RACC when its count expires. ST_RACC goes to ST_RFIN when its count expires, capturing the incoming byte. ST_RFIN returns to ST_IDLE.

Top module: `sram_seq_ctrl`

## Requirements
- R1: In reset and while idle, mem_sel_n is 1, mem_sel is 0, mem_we_n is 1, mem_oe_n is 1, dq_oe is 0 and done is 0.
- R2: A write request is carried out as three phases. First come SETUP_CYC cycles with the memory selected, mem_we_n high and the write byte driven (dq_oe 1). Next come WPULSE_CYC cycles with mem_we_n low and the byte still driven. Last comes one cycle with mem_we_n high, the byte still driven and done at 1. The address shown is the requested one throughout.
- R3: While the memory stays selected from one cycle to the next, mem_addr does not change.
- R4: A read request is carried out as three phases. First come TURN_CYC cycles with the memory selected, mem_oe_n high and dq_oe 0. Next come ACCESS_CYC cycles with mem_oe_n low. Last comes one cycle with the memory deselected and done at 1.
- R5: rdata takes the value of dq_in sampled at the end of the last output-enable cycle. It is valid in the done cycle of a read and keeps that value until the next read completes.
- R6: dq_oe is never 1 while mem_oe_n is 0, and dq_oe is 1 only while the memory is selected.
- R7: mem_we_n and mem_oe_n are never 0 at the same time.
- R8: done is a single-cycle pulse. A request raised while an access is in progress is ignored and causes no extra access.
- R9: mem_sel_n is always the inverse of mem_sel.
- R10: mem_we_n is 0 only while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled only when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte read |
| done | output | 1 | One-cycle end-of-access pulse |
| mem_addr | output | 17 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| dq_out | output | 8 | Data driven toward the memory |
| dq_in | input | 8 | Data returned by the memory |
| dq_oe | output | 1 | Pad drive enable for dq_out |

## Verification
The hardest situations to reach are the phase boundaries: the cycle at which a request arrives exactly as the previous access returns to idle, and requests that arrive mid-access and must be dropped. The bench keeps a queue of expected pin states, filled on each accepted request, and issues new requests in the first cycle the queue runs empty. This makes back-to-back write and read pairs hit the boundary directly. It also holds req high during a busy access with a different address, and checks that no extra phase appears. A small memory model in the bench commits bytes on each rising write strobe and returns them only while output enable is low. Read-back therefore shows whether the strobes and bus turnaround actually moved data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WREC,
        ST_RTRN,
        ST_RACC,
        ST_RFIN
    } seq_state_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/span_timer.sv
module span_timer #(
    parameter int unsigned TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/byte_capture.sv
module byte_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned AW         = 17,
    parameter int unsigned DW         = 8,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned WPULSE_CYC = 2,
    parameter int unsigned TURN_CYC   = 1,
    parameter int unsigned ACCESS_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe
);
    localparam int unsigned MAXC = max4(SETUP_CYC, WPULSE_CYC, TURN_CYC, ACCESS_CYC);
    localparam int unsigned TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] L_SET = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] L_PUL = TW'(WPULSE_CYC - 1);
    localparam logic [TW-1:0] L_TRN = TW'(TURN_CYC - 1);
    localparam logic [TW-1:0] L_ACC = TW'(ACCESS_CYC - 1);

    seq_state_t    state_q, state_d;
    logic          t_load, t_last, capture, accept, sel;
    logic [TW-1:0] t_val;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wd_q;

    span_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
    );

    byte_capture #(.DW(DW)) u_rcap (
        .clk(clk), .rst_n(rst_n), .en(capture), .d(dq_in), .q(rdata)
    );

    assign accept = (state_q == ST_IDLE) && req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= addr;
                wd_q   <= wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) begin
                t_load = 1'b1;
                if (wr) begin
                    state_d = ST_WSET;
                    t_val   = L_SET;
                end else begin
                    state_d = ST_RTRN;
                    t_val   = L_TRN;
                end
            end
            ST_WSET: if (t_last) begin
                state_d = ST_WPUL;
                t_load  = 1'b1;
                t_val   = L_PUL;
            end
            ST_WPUL: if (t_last) state_d = ST_WREC;
            ST_WREC: state_d = ST_IDLE;
            ST_RTRN: if (t_last) begin
                state_d = ST_RACC;
                t_load  = 1'b1;
                t_val   = L_ACC;
            end
            ST_RACC: if (t_last) begin
                state_d = ST_RFIN;
                capture = 1'b1;
            end
            ST_RFIN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel       = (state_q == ST_WSET) || (state_q == ST_WPUL) || (state_q == ST_WREC)
                 || (state_q == ST_RTRN) || (state_q == ST_RACC);
        mem_sel   = sel;
        mem_sel_n = !sel;
        mem_we_n  = (state_q != ST_WPUL);
        mem_oe_n  = (state_q != ST_RACC);
        dq_oe     = (state_q == ST_WSET) || (state_q == ST_WPUL) || (state_q == ST_WREC);
        done      = (state_q == ST_WREC) || (state_q == ST_RFIN);
        mem_addr  = addr_q;
        dq_out    = wd_q;
    end

    AST_BUS_CLASH:   assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (mem_oe_n && mem_sel)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n));   // R7
    AST_SEL_PAIR:    assert property (@(posedge clk) disable iff (!rst_n) mem_sel_n == !mem_sel);       // R9
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_sel);       // R10
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_sel && $past(mem_sel)) |-> $stable(mem_addr)); // R3
    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);              // R8
    AST_RDATA_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_RFIN) |=> (state_q == ST_RFIN) || $stable(rdata)); // R5

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
    localparam int S = 1, WP = 2, T = 1, A = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0, rdata, dq_out, dq_in = 8'h3C;
    logic [16:0] mem_addr;
    logic        done, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, dq_oe;

    sram_seq_ctrl #(.SETUP_CYC(S), .WPULSE_CYC(WP), .TURN_CYC(T), .ACCESS_CYC(A)) u_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .dq_out(dq_out),
        .dq_in(dq_in), .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit sel; bit wel; bit oel; bit drv; bit dn;
        logic [16:0] a; logic [7:0] d; bit chk; logic [7:0] rd; string tag;
    } exp_t;

    exp_t q[$];
    logic [7:0] mem    [logic [16:0]];
    logic [7:0] shadow [logic [16:0]];
    int   nchk = 0, nfail = 0, cyc = 0;
    bit   rd_valid = 0;
    logic [7:0] last_rd;
    logic prev_we_n = 1'b1;

    function automatic logic [7:0] peek(input logic [16:0] a);
        return shadow.exists(a) ? shadow[a] : 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        exp_t e;
        logic [4:0] act_v, exp_v;
        if (q.size() != 0) e = q.pop_front();
        else begin
            e = '{sel:0, wel:0, oel:0, drv:0, dn:0, a:'0, d:'0, chk:0, rd:'0, tag:"R1"};
        end
        act_v = {mem_sel, !mem_we_n, !mem_oe_n, dq_oe, done};
        exp_v = {e.sel, e.wel, e.oel, e.drv, e.dn};
        chk(act_v == exp_v && mem_sel_n == !e.sel, e.tag, "strobes", {27'd0, act_v}, {27'd0, exp_v});
        if (e.sel) chk(mem_addr == e.a, e.tag, "addr", {15'd0, mem_addr}, {15'd0, e.a});
        if (e.drv) chk(dq_out == e.d, e.tag, "dq_out", {24'd0, dq_out}, {24'd0, e.d});
        if (e.chk) begin
            chk(rdata == e.rd, "R5", "rdata", {24'd0, rdata}, {24'd0, e.rd});
            last_rd  = e.rd;
            rd_valid = 1;
        end else if (rd_valid)
            chk(rdata == last_rd, "R5", "rdata held", {24'd0, rdata}, {24'd0, last_rd});
    endtask

    // one cycle: check outputs, update memory model, drive next inputs
    task automatic cycle(input bit rq, input bit w, input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        cyc++;
        compare();
        if (!mem_sel_n && mem_sel && !prev_we_n && mem_we_n) mem[mem_addr] = dq_out;
        prev_we_n = mem_we_n;
        if (mem_sel && !mem_oe_n && mem_we_n)
            dq_in = mem.exists(mem_addr) ? mem[mem_addr] : 8'hA5;
        else
            dq_in = 8'h3C;
        req = rq; wr = w; addr = a; wdata = d;
        if (rq && q.size() == 0) begin
            if (w) begin
                for (int i = 0; i < S; i++)
                    q.push_back('{sel:1, wel:0, oel:0, drv:1, dn:0, a:a, d:d, chk:0, rd:'0, tag:"R2"});
                for (int i = 0; i < WP; i++)
                    q.push_back('{sel:1, wel:1, oel:0, drv:1, dn:0, a:a, d:d, chk:0, rd:'0, tag:"R2"});
                q.push_back('{sel:1, wel:0, oel:0, drv:1, dn:1, a:a, d:d, chk:0, rd:'0, tag:"R2"});
                shadow[a] = d;
            end else begin
                for (int i = 0; i < T; i++)
                    q.push_back('{sel:1, wel:0, oel:0, drv:0, dn:0, a:a, d:'0, chk:0, rd:'0, tag:"R4"});
                for (int i = 0; i < A; i++)
                    q.push_back('{sel:1, wel:0, oel:1, drv:0, dn:0, a:a, d:'0, chk:0, rd:'0, tag:"R4"});
                q.push_back('{sel:0, wel:0, oel:0, drv:0, dn:1, a:a, d:'0, chk:1, rd:peek(a), tag:"R4"});
            end
        end
    endtask

    task automatic op(input bit w, input logic [16:0] a, input logic [7:0] d);
        cycle(1, w, a, d);
        while (q.size() != 0) cycle(0, 0, '0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !dq_oe && !done,
                "R1", "reset outputs", {26'd0, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, dq_oe, done},
                32'b101100);
        end
        rst_n = 1'b1;
        repeat (2) cycle(0, 0, '0, '0);

        op(1, 17'h00000, 8'h5A);                     // R2
        op(1, 17'h1FFFF, 8'hC3);                     // R2 top address
        op(0, 17'h00000, '0);                        // R4 R5
        op(0, 17'h1FFFF, '0);                        // R4 R5
        op(0, 17'h0AAAA, '0);                        // R5 unwritten location
        // R8: request held high during a write with another address is dropped
        cycle(1, 1, 17'h01234, 8'h77);
        while (q.size() > 1) cycle(1, 0, 17'h15555, 8'hEE);
        cycle(0, 0, '0, '0);
        repeat (2) cycle(0, 0, '0, '0);
        op(0, 17'h15555, '0);                        // R8 location must be unwritten
        op(0, 17'h01234, '0);                        // R2 R5
        // back-to-back: new request in the first idle cycle (R3 R6 R7)
        cycle(1, 1, 17'h0F0F0, 8'h00);
        while (q.size() != 0) cycle(0, 0, '0, '0);
        cycle(1, 0, 17'h0F0F0, '0);
        while (q.size() != 0) cycle(0, 0, '0, '0);
        cycle(1, 1, 17'h0F0F0, 8'hFF);
        while (q.size() != 0) cycle(0, 0, '0, '0);
        cycle(1, 0, 17'h0F0F0, '0);
        while (q.size() != 0) cycle(0, 0, '0, '0);
        // R8: request during a read is dropped
        cycle(1, 0, 17'h00000, '0);
        while (q.size() > 1) cycle(1, 1, 17'h00000, 8'h11);
        cycle(0, 0, '0, '0);
        op(0, 17'h00000, '0);                        // R8 data unchanged
        for (int i = 0; i < 8; i++) begin
            op(1, 17'(i * 16411), 8'(i * 37 + 1));   // R2
            op(0, 17'(i * 16411), '0);               // R4
        end
        repeat (3) cycle(0, 0, '0, '0);              // R1 idle
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule